// File: doc/BRIEF.md
# Extended-Data-Out DRAM Device Model

This block is a synthesizable stand-in for an 8-bit-wide extended-data-out DRAM. It is driven by the same active-low strobes a memory controller would produce: row strobe, column strobe, write enable and output enable. It also takes a multiplexed address bus and a byte bus that is split into input data, output data and an output-enable flag. Every pin is sampled on a fast system clock, and each strobe edge is found by comparing two registered samples.

A falling row strobe opens a row. Each falling column strobe then selects a column, and several columns of one row can be reached back to back. The write strobe's level at that moment decides between a read and an early write. A later fall of the write strobe turns a read into a read-modify-write. Read data stays on the bus after the column strobe rises, and it is released only once both strobes are high. A row strobe that falls while the column strobe is already low is a counter-addressed refresh and not an access. This is how hidden refresh works: it keeps the previous read data on the bus. The storage array is a small parameterised block-RAM-style memory with no decay.

Top module: `edo_dram_model`

## Requirements
- R1: After reset, dq_oe is 0 and dq_out is 0.
- R2: The row is taken from addr at the falling ras_n and the column at each falling cas_n. With we_n high and oe_n low, the byte stored at index row*2^COL_BITS+col appears on dq_out with dq_oe=1 within 5 clock cycles of the cas_n fall.
- R3: If we_n is low when cas_n falls, dq_in is stored at the addressed cell, and dq_oe stays 0 for the whole cycle.
- R4: While ras_n stays low, read data stays driven after cas_n rises, and it changes only at the next cas_n fall, to that column's data.
- R5: The output turns off when the later of the two strobes rises. If ras_n rises first, dq_oe drops once cas_n rises. If cas_n rises first, dq_oe drops once ras_n rises.
- R6: A fall of we_n while cas_n is low during a read first leaves the read data on the bus. The fall then stores dq_in at that cell and turns dq_oe off.
- R7: oe_n high forces dq_oe to 0. When oe_n returns low, the held read data is driven again.
- R8: A ras_n low period with cas_n kept high performs no access: dq_oe stays 0 and no cell changes.
- R9: cas_n low before ras_n falls gives a refresh. addr is ignored and no cell changes. The refresh row counter advances by one per refresh and wraps to 0 after REF_ROWS-1.
- R10: Toggling ras_n while cas_n stays low (hidden refresh) keeps the previous read data on dq_out with dq_oe=1.
- R11: A fall of we_n while cas_n is high inside an open row turns dq_oe off and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | max(ROW_BITS,COL_BITS) | Multiplexed row/column address |
| dq_in | input | DATA_BITS | Write data from the bus |
| dq_out | output | DATA_BITS | Read data toward the bus |
| dq_oe | output | 1 | High while the model drives the bus |

## Verification
The bench uses a 16x16 array. First it fills every cell with early writes in page mode, using a value computed from the row and column. It then reads every cell back in page mode, and this sweep separates address latching faults from data path faults. It also checks the held data after each cas_n rise, which would expose a model that releases the bus early. Directed sequences run both strobe release orders, the oe_n gating, a read-modify-write, a RAS-only refresh, twenty counter refreshes with junk on addr, and hidden refresh. A we_n pulse with cas_n high is also applied. A final full read sweep then confirms that no refresh or stray strobe altered the array.

// File: rtl/edo_pkg.sv
package edo_pkg;

  // Kind of column access currently in progress inside an open row
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  // Index of each edge-detected strobe inside the sampled vector
  localparam int STB_RAS = 0;
  localparam int STB_CAS = 1;
  localparam int STB_WE  = 2;
  localparam int STB_NUM = 3;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_strobe_sync.sv
module edo_strobe_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] lvl,
  output logic [N-1:0] fall
);

  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl  <= '1;
      prev <= '1;
    end else begin
      lvl  <= pin_n;
      prev <= lvl;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign fall[i] = prev[i] & ~lvl[i];

    // a detected falling edge lasts exactly one sample
    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      fall[i] |=> !fall[i]); // R2
  end

endmodule

// File: rtl/edo_refresh_ctr.sv
module edo_refresh_ctr #(
  parameter int REF_ROWS = 4096,
  parameter int OUT_BITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  output logic [OUT_BITS-1:0] row_out
);

  localparam int CW = edo_pkg::max_of($clog2(REF_ROWS), OUT_BITS);
  localparam logic [CW-1:0] LAST = CW'(REF_ROWS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign row_out = cnt[OUT_BITS-1:0];

  AST_REF_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && cnt == LAST) |=> (cnt == '0)); // R9

  AST_REF_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1)); // R9

  AST_REF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt)); // R9

endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model #(
  parameter int ROW_BITS  = 4,
  parameter int COL_BITS  = 4,
  parameter int DATA_BITS = 8,
  parameter int REF_ROWS  = 4096,
  localparam int ADDR_W   = edo_pkg::max_of(ROW_BITS, COL_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 oe_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_BITS-1:0] dq_in,
  output logic [DATA_BITS-1:0] dq_out,
  output logic                 dq_oe
);

  import edo_pkg::*;

  localparam int CELL_W = ROW_BITS + COL_BITS;

  // ---------------- pin sampling ----------------
  logic [STB_NUM-1:0] stb_lvl, stb_fall;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_BITS-1:0] din_q;
  logic                 oe_q;

  edo_strobe_sync #(.N(STB_NUM)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_n ({we_n, cas_n, ras_n}),
    .lvl   (stb_lvl),
    .fall  (stb_fall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      din_q  <= '0;
      oe_q   <= 1'b1;
    end else begin
      addr_q <= addr;
      din_q  <= dq_in;
      oe_q   <= oe_n;
    end
  end

  logic ras_q, cas_q, we_q;
  logic ras_fall, cas_fall, we_fall;
  assign ras_q    = stb_lvl[STB_RAS];
  assign cas_q    = stb_lvl[STB_CAS];
  assign we_q     = stb_lvl[STB_WE];
  assign ras_fall = stb_fall[STB_RAS];
  assign cas_fall = stb_fall[STB_CAS];
  assign we_fall  = stb_fall[STB_WE];

  // ---------------- control state ----------------
  logic                 row_open;
  logic [ROW_BITS-1:0]  row_r;
  logic [COL_BITS-1:0]  col_r;
  cyc_e                 cyc;
  logic                 rd_pend;
  logic                 data_valid;
  logic [DATA_BITS-1:0] dout_r;
  logic                 dq_oe_r;

  // ---------------- decode ----------------
  logic                refresh_go;
  logic                col_access;
  logic                early_wr;
  logic                rmw_wr;
  logic [ROW_BITS-1:0] ref_row;
  logic [COL_BITS-1:0] col_in;

  assign col_in     = addr_q[COL_BITS-1:0];
  assign refresh_go = ras_fall & ~cas_q;
  assign col_access = cas_fall & row_open;
  assign early_wr   = col_access & ~we_q;
  assign rmw_wr     = we_fall & row_open & ~cas_q & ~cas_fall & (cyc == CYC_READ);

  // ---------------- array interface ----------------
  logic                 mem_we, mem_re;
  logic [CELL_W-1:0]    mem_waddr, mem_raddr;
  logic [DATA_BITS-1:0] mem_rdata;

  always_comb begin
    mem_we    = early_wr | rmw_wr;
    mem_waddr = early_wr ? {row_r, col_in} : {row_r, col_r};
    mem_re    = (col_access & we_q) | refresh_go;
    mem_raddr = refresh_go ? {ref_row, {COL_BITS{1'b0}}} : {row_r, col_in};
  end

  edo_cell_array #(.AW(CELL_W), .DW(DATA_BITS)) u_cells (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (din_q),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  edo_refresh_ctr #(.REF_ROWS(REF_ROWS), .OUT_BITS(ROW_BITS)) u_refresh (
    .clk     (clk),
    .rst     (rst),
    .step    (refresh_go),
    .row_out (ref_row)
  );

  // ---------------- sequencing ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      row_open   <= 1'b0;
      row_r      <= '0;
      col_r      <= '0;
      cyc        <= CYC_IDLE;
      rd_pend    <= 1'b0;
      data_valid <= 1'b0;
      dout_r     <= '0;
      dq_oe_r    <= 1'b0;
    end else begin
      rd_pend <= 1'b0;

      // row strobe: open a row unless a refresh is requested
      if (ras_q) begin
        row_open <= 1'b0;
      end else if (ras_fall) begin
        row_open <= ~refresh_go;
        if (!refresh_go) begin
          row_r <= addr_q[ROW_BITS-1:0];
        end
      end

      // column strobe inside an open row
      if (col_access) begin
        col_r <= col_in;
        if (!we_q) begin
          cyc        <= CYC_WRITE;
          data_valid <= 1'b0;
        end else begin
          cyc     <= CYC_READ;
          rd_pend <= 1'b1;
        end
      end

      // array data arrives one cycle after the read is issued
      if (rd_pend) begin
        dout_r     <= mem_rdata;
        data_valid <= 1'b1;
      end

      // any write strobe fall in an open row releases the bus
      if (we_fall && row_open) begin
        data_valid <= 1'b0;
      end
      if (rmw_wr) begin
        cyc <= CYC_WRITE;
      end

      // output released once both strobes are high
      if (ras_q && cas_q) begin
        data_valid <= 1'b0;
        cyc        <= CYC_IDLE;
      end

      dq_oe_r <= data_valid & ~oe_q;
    end
  end

  assign dq_out = dout_r;
  assign dq_oe  = dq_oe_r;

  // ---------------- assertions ----------------
  AST_EWRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(cyc == CYC_WRITE) && cyc == CYC_WRITE) |-> !dq_oe); // R3

  AST_OE_GATE: assert property (@(posedge clk) disable iff (rst)
    oe_q |=> !dq_oe); // R7

  AST_OFF_BOTH_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ras_q && cas_q && $past(ras_q && cas_q)) |=> !dq_oe); // R5

  AST_REFRESH_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    refresh_go |-> !mem_we); // R9

  AST_CLOSED_ROW_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!row_open && !cas_fall) |-> !mem_we); // R8

  AST_WRITE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({early_wr, rmw_wr})); // R6

endmodule

// File: tb/edo_dram_model_test.sv
module edo_dram_model_test;

  localparam int RB = 4;
  localparam int CB = 4;
  localparam int DW = 8;
  localparam int NR = 1 << RB;
  localparam int NC = 1 << CB;
  localparam int SETTLE = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [RB-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [DW-1:0] shadow [NR*NC];

  always #5 clk = ~clk;

  edo_dram_model #(
    .ROW_BITS(RB), .COL_BITS(CB), .DATA_BITS(DW), .REF_ROWS(16)
  ) uut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [DW-1:0] pat(input int r, input int c);
    return DW'((r * 37 + c * 11 + 5) & 8'hff);
  endfunction

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic chk_oe(input string req, input logic exp);
    checks++;
    if (dq_oe !== exp) begin
      failures++;
      $display("FAIL %s dq_oe actual=%b expected=%b", req, dq_oe, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [DW-1:0] exp);
    checks++;
    if (dq_oe !== 1'b1 || dq_out !== exp) begin
      failures++;
      $display("FAIL %s oe/data actual=%b/%h expected=1/%h", req, dq_oe, dq_out, exp);
    end
  endtask

  task automatic open_row(input int r);
    addr = RB'(r); ras_n = 1'b0; settle();
  endtask

  task automatic close_all();
    cas_n = 1'b1; we_n = 1'b1; settle();
    ras_n = 1'b1; settle();
  endtask

  // column read inside an already open row
  task automatic col_read(input int c);
    addr = CB'(c); we_n = 1'b1; cas_n = 1'b0; settle();
  endtask

  task automatic sweep_read(input string req);
    for (int r = 0; r < NR; r++) begin
      open_row(r);
      for (int c = 0; c < NC; c++) begin
        col_read(c);
        chk_rd(req, shadow[r*NC+c]);
        cas_n = 1'b1; settle();
        chk_rd("R4 hold after cas rise", shadow[r*NC+c]);
      end
      ras_n = 1'b1; settle();
      chk_oe("R5 cas first, off after ras", 1'b0);
    end
  endtask

  initial begin
    // R1 reset state
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (dq_oe !== 1'b0 || dq_out !== '0) begin
      failures++;
      $display("FAIL R1 oe/data actual=%b/%h expected=0/00", dq_oe, dq_out);
    end

    // R3 fill every cell with early writes in page mode
    for (int r = 0; r < NR; r++) begin
      open_row(r);
      for (int c = 0; c < NC; c++) begin
        addr = CB'(c); dq_in = pat(r, c); we_n = 1'b0; cas_n = 1'b0; settle();
        shadow[r*NC+c] = pat(r, c);
        chk_oe("R3 early write quiet", 1'b0);
        cas_n = 1'b1; we_n = 1'b1; settle();
      end
      ras_n = 1'b1; settle();
    end

    // R2 / R4 full page read sweep
    sweep_read("R2 page read");

    // R5 ras rises first: data held until cas rises
    open_row(3); col_read(9);
    ras_n = 1'b1; settle();
    chk_rd("R5 ras first, still driving", shadow[3*NC+9]);
    cas_n = 1'b1; settle();
    chk_oe("R5 ras first, off after cas", 1'b0);

    // R7 output enable gating
    oe_n = 1'b1;
    open_row(7); col_read(2);
    chk_oe("R7 oe high gates off", 1'b0);
    oe_n = 1'b0; settle();
    chk_rd("R7 oe low redrives", shadow[7*NC+2]);
    close_all();

    // R6 read-modify-write
    open_row(2); col_read(3);
    chk_rd("R6 read phase", shadow[2*NC+3]);
    dq_in = 8'hA5; we_n = 1'b0; settle();
    chk_oe("R6 off after write", 1'b0);
    shadow[2*NC+3] = 8'hA5;
    close_all();
    open_row(2); col_read(3);
    chk_rd("R6 stored value", 8'hA5);
    close_all();

    // R8 RAS-only refresh
    dq_in = 8'h3C; we_n = 1'b0;
    open_row(5);
    chk_oe("R8 ras-only quiet", 1'b0);
    close_all();
    open_row(5); col_read(7);
    chk_rd("R8 array unchanged", shadow[5*NC+7]);
    close_all();

    // R9 counter refresh with junk address, past counter wrap
    for (int k = 0; k < 20; k++) begin
      addr = RB'(k * 5); dq_in = 8'hFF; we_n = 1'b0;
      cas_n = 1'b0; settle();
      ras_n = 1'b0; settle();
      chk_oe("R9 refresh quiet", 1'b0);
      ras_n = 1'b1; settle();
      cas_n = 1'b1; we_n = 1'b1; settle();
    end
    open_row(0); col_read(0);
    chk_rd("R9 array unchanged", shadow[0]);
    close_all();

    // R10 hidden refresh keeps read data
    open_row(9); col_read(14);
    chk_rd("R10 before hidden refresh", shadow[9*NC+14]);
    ras_n = 1'b1; settle();
    addr = '1; ras_n = 1'b0; settle();
    chk_rd("R10 during hidden refresh", shadow[9*NC+14]);
    ras_n = 1'b1; settle();
    chk_rd("R10 after hidden refresh", shadow[9*NC+14]);
    cas_n = 1'b1; settle();
    chk_oe("R10 off when cas rises", 1'b0);

    // R11 write strobe with cas high inside a page
    open_row(11); col_read(4);
    cas_n = 1'b1; settle();
    chk_rd("R11 held before we", shadow[11*NC+4]);
    dq_in = 8'h00; we_n = 1'b0; settle();
    chk_oe("R11 we fall turns off", 1'b0);
    we_n = 1'b1; settle();
    col_read(5);
    chk_rd("R11 next column", shadow[11*NC+5]);
    cas_n = 1'b1; settle();
    col_read(4);
    chk_rd("R11 no write happened", shadow[11*NC+4]);
    close_all();

    // whole array after all the refresh and stray strobes
    sweep_read("R9 final sweep");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule